// File: doc/BRIEF.md
# Multiplexed DRAM Address Sequencer

This block sits between a requester and a dynamic memory whose word address is twice as wide as its address pins. It takes a full word address plus a read or write request, then sends the address over one narrow shared bus in two halves. The upper half (the row) goes first under an active-low row strobe. The lower half (the column) follows under an active-low column strobe. Both strobes sit high while the block is idle.

The lengths of the row phase, the column phase and the closing precharge gap are parameters counted in clock cycles. Each must be at least one. Before each strobe falls, the shared bus is set up for one full clock.

On the requester side the request is a valid/ready transfer. `req_valid` together with `req_we`, `req_addr` and `req_wdata` is taken on any rising edge where `req_ready` is high. `req_ready` is low for the whole operation, so the requester must hold its request until it sees ready high. A valid request that arrives while ready is low is not stored and has no effect on the operation in progress. Completion is marked by a one-cycle `done` pulse. Read data appears on `rd_data` at the same edge as that pulse and holds until the next read finishes.

Top module: `dram_addr_seq`

## Requirements
- R1: After reset, `ras_n`, `cas_n` and `we_n` are 1, `busy` and `done` are 0, `req_ready` is 1, and `mem_addr`, `mem_wdata` and `rd_data` are 0.
- R2: A request accepted at edge 0 puts address bits [15:8] (the row) on `mem_addr` after edge 0. `ras_n` falls at edge 1, so the row has been on the bus for one clock before the strobe falls.
- R3: `ras_n` stays low for exactly ROW_CYC cycles. It rises at edge ROW_CYC+1, and at that same edge address bits [7:0] (the column) replace the row on `mem_addr`.
- R4: `cas_n` falls at edge ROW_CYC+2, one clock after the column appears. It stays low for exactly COL_CYC cycles. `ras_n` and `cas_n` are never low together.
- R5: For a write (`req_we`=1), `we_n` is 0 from edge ROW_CYC+1 until the edge where `cas_n` rises. `mem_wdata` carries the request data from edge 0 onward. For a read, `we_n` stays 1.
- R6: For a read, `rd_data` takes the value of `mem_rdata` sampled at the edge where `cas_n` rises, which is edge ROW_CYC+COL_CYC+2. It holds that value until the next read completes.
- R7: After `cas_n` rises, both strobes stay high for PRE_CYC cycles. Then `busy` falls and `done` is 1 for exactly one cycle, at edge ROW_CYC+COL_CYC+PRE_CYC+2.
- R8: `busy` is 1 and `req_ready` is 0 from the edge after acceptance until `done`. A `req_valid` seen while `req_ready` is 0 is ignored: the address, strobes and data of the operation in progress do not change.
- R9: `mem_addr` does not change while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Full word address; row = upper half, column = lower half |
| req_wdata | input | DATA_W (16) | Data to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W (16) | Data from the last read |
| mem_addr | output | ADDR_W/2 (8) | Shared row/column address bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mem_wdata | output | DATA_W (16) | Write data to the memory |
| mem_rdata | input | DATA_W (16) | Read data from the memory |

## Verification
Each output has a fixed due time, counted in edges from the edge that accepts a request:

- the row appears on the bus after edge 0;
- the row strobe falls at edge 1;
- the column appears at edge ROW_CYC+1;
- the column strobe falls at edge ROW_CYC+2;
- read data is captured at edge ROW_CYC+COL_CYC+2;
- `done` pulses at edge ROW_CYC+COL_CYC+PRE_CYC+2.

The bench keeps a behavioural model that counts those edges and derives every expected output from that count. It compares all outputs on each falling clock edge, so each change is checked in the cycle it is due. A memory model on the pins stores writes and serves reads, so read-back values check the whole path from request to pins and back.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RSETUP,
    PH_ROW,
    PH_CSETUP,
    PH_COL,
    PH_PRE
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int ROW_CYC = 3,
  parameter int COL_CYC = 2,
  parameter int PRE_CYC = 2,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             timer_last,
  output phase_e           phase,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             ras_n,
  output logic             cas_n,
  output logic             done
);
  localparam logic [CNT_W-1:0] ROW_LOAD = CNT_W'(ROW_CYC - 1);
  localparam logic [CNT_W-1:0] COL_LOAD = CNT_W'(COL_CYC - 1);
  localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_CYC - 1);

  phase_e nxt;

  always_comb begin
    nxt        = phase;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (phase)
      PH_IDLE:   if (start) nxt = PH_RSETUP;
      PH_RSETUP: begin nxt = PH_ROW; timer_load = 1'b1; timer_val = ROW_LOAD; end
      PH_ROW:    if (timer_last) nxt = PH_CSETUP;
      PH_CSETUP: begin nxt = PH_COL; timer_load = 1'b1; timer_val = COL_LOAD; end
      PH_COL:    if (timer_last) begin nxt = PH_PRE; timer_load = 1'b1; timer_val = PRE_LOAD; end
      PH_PRE:    if (timer_last) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      done  <= 1'b0;
    end else begin
      phase <= nxt;
      ras_n <= (nxt != PH_ROW);
      cas_n <= (nxt != PH_COL);
      done  <= (phase == PH_PRE) && timer_last;
    end
  end

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ras_n && !cas_n)); // R4
  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (ras_n && cas_n)); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int HALF_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_e            phase,
  input  logic              timer_last,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [HALF_W-1:0] mem_addr,
  output logic              we_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [HALF_W-1:0] row_q, col_q;
  logic              wr_q;
  logic              row_end, col_end;

  assign row_end = (phase == PH_ROW) && timer_last;
  assign col_end = (phase == PH_COL) && timer_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      mem_addr  <= '0;
      we_n      <= 1'b1;
      mem_wdata <= '0;
      rd_data   <= '0;
    end else begin
      if (accept) begin
        row_q     <= req_addr[ADDR_W-1:HALF_W];
        col_q     <= req_addr[HALF_W-1:0];
        wr_q      <= req_we;
        mem_wdata <= req_wdata;
        mem_addr  <= req_addr[ADDR_W-1:HALF_W];
      end else if (row_end) begin
        mem_addr  <= col_q;
      end
      if (row_end)      we_n <= ~wr_q;
      else if (col_end) we_n <= 1'b1;
      if (col_end && !wr_q) rd_data <= mem_rdata;
    end
  end

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ($stable(row_q) && $stable(col_q) && $stable(wr_q))); // R8
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_q |-> we_n); // R5
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int ROW_CYC = 3,
  parameter int COL_CYC = 2,
  parameter int PRE_CYC = 2,
  localparam int HALF_W = ADDR_W / 2,
  localparam int MAX_C  = max3(ROW_CYC, COL_CYC, PRE_CYC),
  localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [HALF_W-1:0] mem_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  phase_e           phase;
  logic             accept;
  logic             t_load, t_last;
  logic [CNT_W-1:0] t_val;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = ~req_ready;
  assign accept    = req_valid && req_ready;

  dram_seq_fsm #(
    .ROW_CYC(ROW_CYC), .COL_CYC(COL_CYC), .PRE_CYC(PRE_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .timer_last(t_last),
    .phase(phase), .timer_load(t_load), .timer_val(t_val),
    .ras_n(ras_n), .cas_n(cas_n), .done(done)
  );

  dram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
  );

  dram_addr_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase(phase), .timer_last(t_last),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .we_n(we_n),
    .mem_wdata(mem_wdata), .rd_data(rd_data)
  );

  AST_ROW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(mem_addr)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> $stable(mem_addr)); // R9
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> ($stable(we_n) && $stable(mem_wdata))); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($fell(busy) && ras_n && cas_n)); // R7
endmodule

// File: tb/dram_addr_seq_tb.sv
module dram_addr_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int R = 3, C = 2, P = 2;
  localparam int T_COLIN = R + 1, T_CASLO = R + 2, T_CASHI = R + C + 2, T_DONE = R + C + P + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic req_ready, busy, done, ras_n, cas_n, we_n;
  logic [15:0] rd_data, mem_wdata;
  logic [7:0] mem_addr;

  int checks = 0, fails = 0;

  dram_addr_seq #(.ROW_CYC(R), .COL_CYC(C), .PRE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] dflt(input logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction

  // memory model on the pins
  logic [15:0] env_mem [logic [15:0]];
  logic [7:0]  env_row = '0;
  always @(negedge clk) begin
    if (!ras_n) env_row = mem_addr;
    if (!cas_n && !we_n) env_mem[{env_row, mem_addr}] = mem_wdata;
    if (!cas_n) mem_rdata = env_mem.exists({env_row, mem_addr}) ? env_mem[{env_row, mem_addr}]
                                                                 : dflt({env_row, mem_addr});
  end

  // behavioural reference
  logic [15:0] ref_mem [logic [15:0]];
  bit active = 0;
  int t = 0;
  logic        m_we = 0;
  logic [15:0] m_addr = '0, m_wdata = '0, m_rd = '0;

  function automatic bit m_busy();
    return active && t < T_DONE;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      active = 0; t = 0; m_we = 0; m_addr = '0; m_wdata = '0; m_rd = '0;
    end else begin
      bit acc;
      acc = req_valid && !m_busy();
      if (active) begin
        t++;
        if (t == T_CASHI) begin
          if (m_we) ref_mem[m_addr] = m_wdata;
          else m_rd = ref_mem.exists(m_addr) ? ref_mem[m_addr] : dflt(m_addr);
        end
        if (t > T_DONE) active = 0;
      end
      if (acc) begin
        active = 1; t = 0; m_we = req_we; m_addr = req_addr; m_wdata = req_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act, exp);
    end
  endtask

  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      bit         b, rl, cl, wl;
      logic [7:0] ea;
      b  = m_busy();
      rl = active && t >= 1 && t <= R;
      cl = active && t >= T_CASLO && t < T_CASHI;
      wl = active && m_we && t >= T_COLIN && t < T_CASHI;
      ea = (active && t < T_COLIN) ? m_addr[15:8] : m_addr[7:0];
      chk("R8 busy",      16'(busy), 16'(b));
      chk("R8 req_ready", 16'(req_ready), 16'(!b));
      chk("R3 ras_n",     16'(ras_n), 16'(!rl));
      chk("R4 cas_n",     16'(cas_n), 16'(!cl));
      chk((rl || cl) ? "R9 mem_addr" : "R2 mem_addr", 16'(mem_addr), 16'(ea));
      chk("R5 we_n",      16'(we_n), 16'(!wl));
      chk("R5 mem_wdata", mem_wdata, m_wdata);
      chk("R6 rd_data",   rd_data, m_rd);
      chk("R7 done",      16'(done), 16'(active && t == T_DONE));
    end
  end

  task automatic issue(input logic we, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ras_n", 16'(ras_n), 16'd1);
    chk("R1 cas_n", 16'(cas_n), 16'd1);
    chk("R1 we_n",  16'(we_n),  16'd1);
    chk("R1 busy",  16'(busy),  16'd0);
    chk("R1 done",  16'(done),  16'd0);
    chk("R1 ready", 16'(req_ready), 16'd1);
    chk("R1 mem_addr", 16'(mem_addr), 16'd0);
    chk("R1 rd_data", rd_data, 16'd0);
    cmp_en = 1;

    issue(1, 16'h12AB, 16'hBEEF); wait_done();
    issue(1, 16'h0000, 16'h1111); wait_done();
    issue(1, 16'hFFFF, 16'h8001); wait_done();
    issue(0, 16'h12AB, 16'h0);    wait_done();   // R6 read-back
    issue(0, 16'hFFFF, 16'h0);    wait_done();
    issue(0, 16'h3C5A, 16'h0);    wait_done();   // unwritten location

    // R8: requests while busy are ignored
    issue(1, 16'h4242, 16'h7777);
    repeat (3) @(negedge clk);
    req_valid = 1; req_we = 1; req_addr = 16'h9999; req_wdata = 16'hDEAD;
    repeat (2) @(negedge clk);
    req_valid = 0;
    wait_done();
    issue(0, 16'h4242, 16'h0); wait_done();
    issue(0, 16'h9999, 16'h0); wait_done();

    // back-to-back: valid held high, accepted at first ready
    @(negedge clk);
    req_valid = 1; req_we = 0; req_addr = 16'h0000;
    wait_done();
    @(negedge clk);
    req_addr = 16'h12AB;
    @(negedge clk);
    req_valid = 0;
    wait_done();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule